// File: doc/BRIEF.md
# Sector Erase Suspend/Resume Scheduler

This block sequences multi-sector erase operations for a NOR-style flash command path. The command decoder above it hands in one-cycle strobes for sector erase, erase suspend, erase resume, chip erase and program. Each sector erase marks its sector in a bitmap and reopens a short accept window, so that further sectors can join the same operation. When the window lapses, an erase timer starts. Its length is 2^N milliseconds per queued sector, and N is supplied on `blk_exp`.

A suspend command freezes the erase and keeps the time still owed. If the suspend lands inside the accept window, the time owed is the full computed duration. If it lands during the erase, the time owed is what is left on the timer. A resume reloads that time. While the erase is suspended, the block screens later commands. Another erase request asks the decoder to fall back to read mode. A program aimed at a marked sector is refused: it returns to bypass if bypass is active, and otherwise resets to read mode. A program aimed at any other sector is granted.

All time is counted on the `us_tick` enable, which pulses once per microsecond. The command inputs are plain strobes with no flow control, because the decoder issues at most one command per clock. If several strobes do arrive together, the order of precedence is suspend, then resume, then sector erase, then chip erase, then program.

Top module: `erase_sched`

## Requirements
- R1: After reset, dq3 is 0, dq7 is 1, suspended is 0, sector_map is all zero, and erase_done, read_reset, bypass_ret and prog_grant are all 0.
- R2: A sector erase received while idle and not suspended, or while the accept window is open, does three things. It sets bit `cmd_sec` of sector_map, drives dq7 to 0, and restarts the accept window at WINDOW_US ticks. dq3 becomes 1 exactly WINDOW_US ticks after the last such command.
- R3: When dq3 rises, the erase lasts (2^blk_exp × US_PER_MS × queued sectors) ticks. It then ends with a one-cycle erase_done, and in the same cycle sector_map and the queued count clear, dq3 returns to 0 and dq7 returns to 1.
- R4: A suspend during the accept window saves the full erase duration for the queued sectors. A suspend during the erase saves the timer's remaining ticks, with a minimum of 1.
- R5: On suspend, the timers stop and dq3 goes to 0. suspended is 1 exactly while a nonzero saved time is held, and sector_map keeps its bits.
- R6: A resume while suspended reloads the erase timer with the saved time and clears the saved time. In the following cycle dq3 is 1, dq7 is 0 and suspended is 0, and erase_done follows after exactly the saved number of ticks.
- R7: A resume that arrives when no erase is suspended produces a one-cycle read_reset and changes no erase state.
- R8: A suspend that arrives while idle, or while already suspended, is ignored. It produces no pulse, and it neither changes the saved time nor changes suspended.
- R9: A sector erase or chip erase that arrives while suspended, or a sector erase that arrives during the active erase, produces read_reset and leaves sector_map unchanged.
- R10: A program received while suspended to a sector whose sector_map bit is 1 gives bypass_ret when bypass_active is 1, and read_reset otherwise. A program to a sector whose bit is 0, or a program received while idle, gives prog_grant.
- R11: The accept window and the erase timer advance only in cycles where us_tick is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-microsecond count enable |
| blk_exp | input | 4 | Per-sector erase exponent N (2^N ms) |
| cmd_sec_erase | input | 1 | Sector erase command strobe |
| cmd_sec | input | SEC_W | Sector index for sector erase |
| cmd_suspend | input | 1 | Erase suspend strobe |
| cmd_resume | input | 1 | Erase resume strobe |
| cmd_chip_erase | input | 1 | Chip erase strobe |
| cmd_prog | input | 1 | Program request strobe |
| prog_sec | input | SEC_W | Sector index of program target |
| bypass_active | input | 1 | Decoder is in unlock-bypass state |
| dq3 | output | 1 | Erase-timer-running status bit |
| dq7 | output | 1 | Data-polling status bit (0 while erase pending) |
| suspended | output | 1 | Erase suspend mode active |
| erase_done | output | 1 | One-cycle erase completion pulse |
| read_reset | output | 1 | One-cycle request to return to read mode |
| bypass_ret | output | 1 | One-cycle request to return to bypass state |
| prog_grant | output | 1 | One-cycle program acceptance |
| sector_map | output | NUM_SECTORS | Sectors marked for erase |

## Verification
Every output is registered. A strobe held across one rising edge therefore shows its pulse or status change at the very next falling-edge sample. With us_tick high, dq3 rises WINDOW_US edges after the last sector command, and erase_done appears a further (2^N × US_PER_MS × count) edges after that. After a resume, erase_done appears exactly the saved number of edges later. The bench counts falling edges from the command edge and records the first edge at which each result appears. It compares that edge number with the value computed arithmetically from these formulas, over a sweep of every exponent and sector count in a small configuration and over suspend points placed inside the window and inside the erase.

// File: rtl/erase_sched_pkg.sv
package erase_sched_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WINDOW = 2'd1,
    ST_ERASE  = 2'd2
  } sched_state_e;

  // Erase duration in ticks: 2^exp milliseconds per queued sector.
  function automatic logic [31:0] erase_ticks(input logic [3:0] exp_n,
                                              input logic [31:0] sectors,
                                              input logic [31:0] ticks_per_ms);
    return ((32'd1 << exp_n) * ticks_per_ms) * sectors;
  endfunction

endpackage

// File: rtl/es_countdown.sv
module es_countdown #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic         stop,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         expire
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (stop)                   cnt_q <= '0;
    else if (load)                   cnt_q <= load_val;
    else if (tick && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign cnt    = cnt_q;
  assign expire = tick && !load && !stop && (cnt_q == W'(1));
endmodule

// File: rtl/es_sector_map.sv
module es_sector_map #(
  parameter int NS = 8,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [SW-1:0] set_idx,
  input  logic          clr,
  output logic [NS-1:0] map
);
  for (genvar i = 0; i < NS; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n || clr)                        bit_q <= 1'b0;
      else if (set_en && set_idx == SW'(i))     bit_q <= 1'b1;
    end
    assign map[i] = bit_q;
  end
endmodule

// File: rtl/erase_sched.sv
module erase_sched
  import erase_sched_pkg::*;
#(
  parameter int NUM_SECTORS = 8,
  parameter int WINDOW_US   = 50,
  parameter int US_PER_MS   = 1000,
  localparam int SEC_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1,
  localparam int CNT_W = $clog2(NUM_SECTORS + 1) + 1,
  localparam int TW    = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   us_tick,
  input  logic [3:0]             blk_exp,
  input  logic                   cmd_sec_erase,
  input  logic [SEC_W-1:0]       cmd_sec,
  input  logic                   cmd_suspend,
  input  logic                   cmd_resume,
  input  logic                   cmd_chip_erase,
  input  logic                   cmd_prog,
  input  logic [SEC_W-1:0]       prog_sec,
  input  logic                   bypass_active,
  output logic                   dq3,
  output logic                   dq7,
  output logic                   suspended,
  output logic                   erase_done,
  output logic                   read_reset,
  output logic                   bypass_ret,
  output logic                   prog_grant,
  output logic [NUM_SECTORS-1:0] sector_map
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  sched_state_e     state_q, state_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic [TW-1:0]    saved_q, saved_d;
  logic             dq3_q, dq3_d, dq7_q, dq7_d;
  logic             done_q, done_d, rr_q, rr_d, bp_q, bp_d, pg_q, pg_d;

  logic             map_set, map_clr;
  logic             win_load, win_stop, win_exp;
  logic             er_load, er_stop, er_exp;
  logic [TW-1:0]    er_val, er_cnt, win_cnt, full_time;
  logic             susp_mode;

  assign susp_mode = (saved_q != '0);
  assign full_time = erase_ticks(blk_exp, TW'(count_q), TW'(US_PER_MS));

  es_countdown #(.W(TW)) win_i (
    .clk(clk), .rst_n(rst_n), .tick(us_tick), .load(win_load), .stop(win_stop),
    .load_val(TW'(WINDOW_US)), .cnt(win_cnt), .expire(win_exp));

  es_countdown #(.W(TW)) ers_i (
    .clk(clk), .rst_n(rst_n), .tick(us_tick), .load(er_load), .stop(er_stop),
    .load_val(er_val), .cnt(er_cnt), .expire(er_exp));

  es_sector_map #(.NS(NUM_SECTORS)) map_i (
    .clk(clk), .rst_n(rst_n), .set_en(map_set), .set_idx(cmd_sec),
    .clr(map_clr), .map(sector_map));

  always_comb begin
    state_d = state_q;  count_d = count_q;  saved_d = saved_q;
    dq3_d = dq3_q;  dq7_d = dq7_q;
    done_d = 1'b0;  rr_d = 1'b0;  bp_d = 1'b0;  pg_d = 1'b0;
    map_set = 1'b0;  map_clr = 1'b0;
    win_load = 1'b0;  win_stop = 1'b0;
    er_load = 1'b0;  er_stop = 1'b0;  er_val = saved_q;

    case (state_q)
      ST_IDLE: begin
        if (susp_mode) begin
          if (cmd_suspend) begin
            // nested suspend: ignored
          end else if (cmd_resume) begin
            er_load = 1'b1;  er_val = saved_q;  saved_d = '0;
            dq3_d = 1'b1;  dq7_d = 1'b0;  state_d = ST_ERASE;
          end else if (cmd_sec_erase || cmd_chip_erase) begin
            rr_d = 1'b1;
          end else if (cmd_prog) begin
            if (sector_map[prog_sec]) begin
              if (bypass_active) bp_d = 1'b1;
              else               rr_d = 1'b1;
            end else begin
              pg_d = 1'b1;
            end
          end
        end else begin
          if (cmd_suspend) begin
            // nothing to suspend
          end else if (cmd_resume) begin
            rr_d = 1'b1;
          end else if (cmd_sec_erase) begin
            map_set = 1'b1;  win_load = 1'b1;  dq7_d = 1'b0;
            count_d = (count_q == CNT_MAX) ? count_q : count_q + 1'b1;
            state_d = ST_WINDOW;
          end else if (cmd_prog) begin
            pg_d = 1'b1;
          end
        end
      end

      ST_WINDOW: begin
        if (cmd_suspend) begin
          saved_d = full_time;  win_stop = 1'b1;  dq3_d = 1'b0;
          state_d = ST_IDLE;
        end else if (cmd_resume) begin
          rr_d = 1'b1;
        end else if (cmd_sec_erase) begin
          map_set = 1'b1;  win_load = 1'b1;
          count_d = (count_q == CNT_MAX) ? count_q : count_q + 1'b1;
        end else if (cmd_chip_erase || cmd_prog) begin
          rr_d = 1'b1;
        end
        if (win_exp) begin
          er_load = 1'b1;  er_val = full_time;  dq3_d = 1'b1;
          state_d = ST_ERASE;
        end
      end

      ST_ERASE: begin
        if (cmd_suspend) begin
          saved_d = (er_cnt == '0) ? TW'(1) : er_cnt;
          er_stop = 1'b1;  dq3_d = 1'b0;  state_d = ST_IDLE;
        end else if (cmd_resume || cmd_sec_erase || cmd_chip_erase || cmd_prog) begin
          rr_d = 1'b1;
        end
        if (er_exp) begin
          map_clr = 1'b1;  count_d = '0;  dq3_d = 1'b0;  dq7_d = 1'b1;
          done_d = 1'b1;  state_d = ST_IDLE;
        end
      end

      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;  count_q <= '0;  saved_q <= '0;
      dq3_q <= 1'b0;  dq7_q <= 1'b1;
      done_q <= 1'b0;  rr_q <= 1'b0;  bp_q <= 1'b0;  pg_q <= 1'b0;
    end else begin
      state_q <= state_d;  count_q <= count_d;  saved_q <= saved_d;
      dq3_q <= dq3_d;  dq7_q <= dq7_d;
      done_q <= done_d;  rr_q <= rr_d;  bp_q <= bp_d;  pg_q <= pg_d;
    end
  end

  assign dq3        = dq3_q;
  assign dq7        = dq7_q;
  assign suspended  = susp_mode;
  assign erase_done = done_q;
  assign read_reset = rr_q;
  assign bypass_ret = bp_q;
  assign prog_grant = pg_q;
endmodule

// File: rtl/erase_sched_chk.sv
module erase_sched_chk #(
  parameter int NS        = 8,
  parameter int WINDOW_US = 50
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_suspend,
  input logic          cmd_resume,
  input logic          dq3,
  input logic          dq7,
  input logic          suspended,
  input logic          erase_done,
  input logic          read_reset,
  input logic          bypass_ret,
  input logic          prog_grant,
  input logic [NS-1:0] sector_map,
  input logic [31:0]   win_cnt
);
  p_window_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    win_cnt <= 32'(WINDOW_US));

  p_done_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    erase_done |-> (sector_map == '0) && !dq3 && dq7);

  p_susp_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> $past(cmd_suspend));

  p_dq3_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> !dq3);

  p_resume_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && cmd_resume) |=> (dq3 && !dq7 && !suspended));

  p_bad_resume_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspended && cmd_resume && !cmd_suspend) |=> read_reset);

  p_map_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && !cmd_resume) |=> $stable(sector_map));

  p_one_answer_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({read_reset, bypass_ret, prog_grant}));
endmodule

bind erase_sched erase_sched_chk #(.NS(NUM_SECTORS), .WINDOW_US(WINDOW_US)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume),
  .dq3(dq3), .dq7(dq7), .suspended(suspended), .erase_done(erase_done),
  .read_reset(read_reset), .bypass_ret(bypass_ret), .prog_grant(prog_grant),
  .sector_map(sector_map), .win_cnt(win_cnt));

// File: tb/erase_sched_tb_top.sv
module erase_sched_tb_top;
  localparam int NS  = 4;
  localparam int W   = 3;
  localparam int UPM = 2;
  localparam int SW  = 2;

  logic clk = 1'b0, rst_n = 1'b0, us_tick = 1'b1;
  logic [3:0] blk_exp = 4'd0;
  logic cmd_sec_erase = 0, cmd_suspend = 0, cmd_resume = 0, cmd_chip_erase = 0, cmd_prog = 0;
  logic [SW-1:0] cmd_sec = '0, prog_sec = '0;
  logic bypass_active = 0;
  logic dq3, dq7, suspended, erase_done, read_reset, bypass_ret, prog_grant;
  logic [NS-1:0] sector_map;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  erase_sched #(.NUM_SECTORS(NS), .WINDOW_US(W), .US_PER_MS(UPM)) dut_i (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .blk_exp(blk_exp),
    .cmd_sec_erase(cmd_sec_erase), .cmd_sec(cmd_sec), .cmd_suspend(cmd_suspend),
    .cmd_resume(cmd_resume), .cmd_chip_erase(cmd_chip_erase), .cmd_prog(cmd_prog),
    .prog_sec(prog_sec), .bypass_active(bypass_active), .dq3(dq3), .dq7(dq7),
    .suspended(suspended), .erase_done(erase_done), .read_reset(read_reset),
    .bypass_ret(bypass_ret), .prog_grant(prog_grant), .sector_map(sector_map));

  function automatic int tval(int n, int c);
    return (1 << n) * UPM * c;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One strobe held across one rising edge; returns at the next falling edge.
  task automatic do_erase(input int s);
    cmd_sec_erase = 1; cmd_sec = SW'(s); @(negedge clk); cmd_sec_erase = 0;
  endtask
  task automatic do_susp();
    cmd_suspend = 1; @(negedge clk); cmd_suspend = 0;
  endtask
  task automatic do_resume();
    cmd_resume = 1; @(negedge clk); cmd_resume = 0;
  endtask
  task automatic do_chip();
    cmd_chip_erase = 1; @(negedge clk); cmd_chip_erase = 0;
  endtask
  task automatic do_prog(input int s, input bit byp);
    cmd_prog = 1; prog_sec = SW'(s); bypass_active = byp; @(negedge clk);
    cmd_prog = 0; bypass_active = 0;
  endtask

  // Count edges until dq3 is high and until erase_done pulses.
  task automatic run_erase(input string tag, input int exp_k3, input int exp_kd);
    int k3 = -1, kd = -1;
    for (int k = 0; k < 600 && kd < 0; k++) begin
      if (dq3 && k3 < 0) k3 = k;
      if (erase_done) kd = k;
      else @(negedge clk);
    end
    check({tag, " dq3 edge R2"}, k3, exp_k3);
    check({tag, " done edge R3"}, kd, exp_kd);
    check({tag, " map cleared R3"}, int'(sector_map), 0);
    check({tag, " dq7 back R3"}, int'(dq7), 1);
    @(negedge clk);
    check({tag, " dq3 low R3"}, int'(dq3), 0);
  endtask

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    if (!finished) begin
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 dq3", int'(dq3), 0);
    check("R1 dq7", int'(dq7), 1);
    check("R1 suspended", int'(suspended), 0);
    check("R1 map", int'(sector_map), 0);
    check("R1 pulses", int'({erase_done, read_reset, bypass_ret, prog_grant}), 0);

    // R8 suspend while idle is ignored
    do_susp();
    check("R8 idle suspend", int'(suspended), 0);
    check("R8 idle suspend pulse", int'(read_reset), 0);
    // R7 resume outside suspend
    do_resume();
    check("R7 read_reset", int'(read_reset), 1);
    check("R7 dq3 unchanged", int'(dq3), 0);
    // R10 program while idle
    do_prog(1, 0);
    check("R10 idle grant", int'(prog_grant), 1);

    // R2/R3 sweep over exponent and sector count
    for (int n = 0; n < 4; n++) begin
      for (int c = 1; c <= NS; c++) begin
        blk_exp = 4'(n);
        for (int s = 0; s < c; s++) do_erase(s);
        check($sformatf("R2 map n%0d c%0d", n, c), int'(sector_map), (1 << c) - 1);
        check($sformatf("R2 dq7 n%0d c%0d", n, c), int'(dq7), 0);
        run_erase($sformatf("sweep n%0d c%0d", n, c), W, W + tval(n, c));
      end
    end

    // R11 ticks gate the window
    blk_exp = 4'd0;
    us_tick = 0;
    do_erase(2);
    repeat (10) @(negedge clk);
    check("R11 no tick dq3", int'(dq3), 0);
    us_tick = 1;
    run_erase("R11 gated", W, W + tval(0, 1));

    // R4 suspend inside window saves full duration
    blk_exp = 4'd1;
    do_erase(0);
    do_erase(2);
    do_susp();
    check("R5 suspended", int'(suspended), 1);
    check("R5 dq3 low", int'(dq3), 0);
    check("R5 map kept", int'(sector_map), 5);
    repeat (20) @(negedge clk);
    check("R5 still suspended", int'(suspended), 1);
    check("R5 no done", int'(dq3), 0);
    do_susp();
    check("R8 nested suspend", int'(suspended), 1);
    do_erase(1);
    check("R9 erase while suspended", int'(read_reset), 1);
    check("R9 map unchanged", int'(sector_map), 5);
    do_chip();
    check("R9 chip while suspended", int'(read_reset), 1);
    do_prog(0, 1);
    check("R10 marked bypass", int'(bypass_ret), 1);
    check("R10 marked bypass no reset", int'(read_reset), 0);
    do_prog(2, 0);
    check("R10 marked reset", int'(read_reset), 1);
    do_prog(1, 0);
    check("R10 unmarked grant", int'(prog_grant), 1);
    do_resume();
    check("R6 dq3", int'(dq3), 1);
    check("R6 dq7", int'(dq7), 0);
    check("R6 suspended", int'(suspended), 0);
    run_erase("R4 window resume", 0, tval(1, 2));

    // R4 suspend during erase saves remaining ticks
    blk_exp = 4'd2;
    do_erase(3);
    for (int k = 0; k < 50 && !dq3; k++) @(negedge clk);
    do_erase(0);
    check("R9 erase during erase", int'(read_reset), 1);
    check("R9 map during erase", int'(sector_map), 8);
    do_resume();
    check("R7 resume during erase", int'(read_reset), 1);
    @(negedge clk);
    do_susp();
    check("R5 suspended mid-erase", int'(suspended), 1);
    repeat (10) @(negedge clk);
    do_resume();
    run_erase("R4 erase resume", 0, tval(2, 1) - 3);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule